// File: doc/BRIEF.md
# SD Command Line Sequencer

This block runs in the card clock domain and carries out one SD command on the CMD line at a time. It waits in idle until an upstream controller raises a start request. At that point it captures a 6-bit command index, a 32-bit argument and a 2-bit response-kind code. It then shifts out a 48-bit command frame, most significant bit first, with a CRC7 that it computes itself. If a reply is expected, it watches the line for a start bit and collects either a 48-bit or a 136-bit reply.

Completion, reply arrival, reply CRC mismatch and reply timeout are reported as level flags. Each flag stays high until the next command starts, so a two-flop synchronizer and edge detector in another clock domain can sample it safely. The current state is exported as a 3-bit code. The upstream controller drops its start request when it sees the send state. After a command finishes, the block does not accept a new one until that request has gone low.

Top module: `sd_cmd_sequencer`

## Requirements
- R1: A command starts only from idle (state code 0) on a clock edge where `start_req` is high. With `start_req` low the block stays idle and `cmd_oe` stays low. The start edge clears all four status flags.
- R2: On the edge after the start, the state becomes send (code 1). For exactly 48 clocks `cmd_oe` is high and `cmd_out` carries the frame MSB first: bit 0, bit 1, the index, the argument, the CRC7, then bit 1. Outside send, `cmd_oe` is low and `cmd_out` is 1.
- R3: The frame CRC7 uses polynomial x^7+x^3+1 with a zero seed, over the first 40 frame bits. Index 0 with argument 0 gives 7'h4A, and index 17 with argument 0 gives 7'h2A.
- R4: `cmd_done` rises on the edge that ends the 48th frame bit and stays high until the next start.
- R5: `resp_kind` is decoded as follows: 00 means no reply, 01 means a 136-bit reply, and 10 or 11 mean a 48-bit reply. The code is latched at the start.
- R6: For a 48-bit reply, `resp_w0` holds reply bits 39..8 and `resp_w1[5:0]` holds reply bits 45..40, with all other word bits zero. `resp_done` rises on the edge that samples the last reply bit, together with the words. The state then goes to hold (code 5).
- R7: For a 136-bit reply, the 128 bits after the 8-bit header land in `resp_w3` (received first) down to `resp_w0` (received last).
- R8: For a 48-bit reply, `resp_crc_err` goes high when the CRC7 of reply bits 47..8 differs from reply bits 7..1. It never goes high for a 136-bit reply.
- R9: In the wait state (code 2), a low `cmd_in` sampled on any of the first `TIMEOUT_CLKS` edges starts reception (state code 3). If all of those edges see high, `resp_timeout` rises on the last of them and the state goes to hold.
- R10: With no reply expected, the block sits in the gap state (code 4) for `GAP_CLKS` clocks and then enters hold. It raises neither `resp_done` nor `resp_timeout`.
- R11: Hold is left for idle only on an edge where `start_req` is low.
- R12: After reset: idle, `cmd_oe` low, `cmd_out` high, all flags low, all reply words zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Registered request to issue a command |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| resp_kind | input | 2 | Reply kind code |
| cmd_in | input | 1 | Sampled CMD line |
| cmd_out | output | 1 | CMD line drive value |
| cmd_oe | output | 1 | CMD line drive enable |
| state_o | output | 3 | Current state code |
| cmd_done | output | 1 | Frame fully sent |
| resp_done | output | 1 | Reply fully received |
| resp_timeout | output | 1 | No reply start bit in time |
| resp_crc_err | output | 1 | Short reply CRC mismatch |
| resp_w0 | output | 32 | Reply word 0 |
| resp_w1 | output | 32 | Reply word 1 |
| resp_w2 | output | 32 | Reply word 2 |
| resp_w3 | output | 32 | Reply word 3 |

## Verification
The assertions assume that `start_req` follows the upstream handshake. It rises only while the block is idle and falls only after the send state has been seen, or deliberately later to exercise hold. They also assume that `cmd_in` stays high while the block drives the line. The bench drives every input at the falling edge and keeps `cmd_in` high except while it plays back a reply frame. It lowers `start_req` at the first sample that shows the send state, except in the one scenario that holds it high on purpose to observe the hold state.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SEND = 3'd1,
        ST_WAIT = 3'd2,
        ST_RECV = 3'd3,
        ST_GAP  = 3'd4,
        ST_HOLD = 3'd5
    } sdc_state_e;

    typedef enum logic [1:0] {
        RSP_NONE  = 2'd0,
        RSP_LONG  = 2'd1,
        RSP_SHORT = 2'd2
    } rsp_len_e;

    localparam int CMD_BITS   = 48;
    localparam int SHORT_BITS = 48;
    localparam int LONG_BITS  = 136;
    localparam int CRC_SPAN   = 40;
    localparam int WORD_W     = 32;
    localparam int KEEP_BITS  = 4 * WORD_W;

    function automatic rsp_len_e decode_rsp(input logic [1:0] code);
        rsp_len_e r;
        case (code)
            2'b00:   r = RSP_NONE;
            2'b01:   r = RSP_LONG;
            default: r = RSP_SHORT;
        endcase
        return r;
    endfunction

    // CRC7, polynomial x^7 + x^3 + 1, zero seed, MSB first
    function automatic logic [6:0] crc7_calc(input logic [CRC_SPAN-1:0] d);
        logic [6:0] c;
        logic       fb;
        c = '0;
        for (int i = CRC_SPAN - 1; i >= 0; i--) begin
            fb = d[i] ^ c[6];
            c  = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

endpackage

// File: rtl/sdc_tx_shifter.sv
module sdc_tx_shifter
    import sdc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic        shift,
    input  logic [5:0]  idx,
    input  logic [31:0] arg,
    output logic        bit_out
);

    logic [CMD_BITS-1:0] sh;
    logic [CRC_SPAN-1:0] head;

    assign head = {2'b01, idx, arg};

    always_ff @(posedge clk) begin
        if (rst)
            sh <= '1;
        else if (load)
            sh <= {head, crc7_calc(head), 1'b1};
        else if (shift)
            sh <= {sh[CMD_BITS-2:0], 1'b1};
    end

    assign bit_out = sh[CMD_BITS-1];

endmodule

// File: rtl/sdc_rx_capture.sv
module sdc_rx_capture
    import sdc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              shift,
    input  logic              finish,
    input  logic              is_long,
    input  logic              bit_in,
    output logic [WORD_W-1:0] w0,
    output logic [WORD_W-1:0] w1,
    output logic [WORD_W-1:0] w2,
    output logic [WORD_W-1:0] w3,
    output logic              crc_bad
);

    // only the last 128 bits of any reply are kept; a short reply fits inside
    logic [KEEP_BITS-2:0] rx;
    logic [KEEP_BITS-1:0] nx;

    assign nx = {rx, bit_in};

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            rx      <= '0;
            w0      <= '0;
            w1      <= '0;
            w2      <= '0;
            w3      <= '0;
            crc_bad <= 1'b0;
        end else begin
            if (shift) rx <= nx[KEEP_BITS-2:0];
            if (finish) begin
                if (is_long) begin
                    w3      <= nx[4*WORD_W-1:3*WORD_W];
                    w2      <= nx[3*WORD_W-1:2*WORD_W];
                    w1      <= nx[2*WORD_W-1:WORD_W];
                    w0      <= nx[WORD_W-1:0];
                    crc_bad <= 1'b0;
                end else begin
                    w0      <= nx[SHORT_BITS-9:8];
                    w1      <= {{(WORD_W-6){1'b0}}, nx[SHORT_BITS-3:SHORT_BITS-8]};
                    w2      <= '0;
                    w3      <= '0;
                    crc_bad <= (crc7_calc(nx[SHORT_BITS-1:8]) != nx[7:1]);
                end
            end
        end
    end

endmodule

// File: rtl/sd_cmd_sequencer.sv
module sd_cmd_sequencer
    import sdc_pkg::*;
#(
    parameter int TIMEOUT_CLKS = 64,
    parameter int GAP_CLKS     = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_req,
    input  logic [5:0]  cmd_index,
    input  logic [31:0] cmd_arg,
    input  logic [1:0]  resp_kind,
    input  logic        cmd_in,
    output logic        cmd_out,
    output logic        cmd_oe,
    output logic [2:0]  state_o,
    output logic        cmd_done,
    output logic        resp_done,
    output logic        resp_timeout,
    output logic        resp_crc_err,
    output logic [31:0] resp_w0,
    output logic [31:0] resp_w1,
    output logic [31:0] resp_w2,
    output logic [31:0] resp_w3
);

    localparam int MAX_A   = (LONG_BITS > TIMEOUT_CLKS) ? LONG_BITS : TIMEOUT_CLKS;
    localparam int CNT_MAX = (MAX_A > GAP_CLKS) ? MAX_A : GAP_CLKS;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    sdc_state_e       st;
    rsp_len_e         len_q;
    logic [CNT_W-1:0] cnt;
    logic             go, rx_hit, rx_last, tx_bit;

    assign go      = (st == ST_IDLE) && start_req;
    assign rx_hit  = (st == ST_WAIT) && !cmd_in;
    assign rx_last = (st == ST_RECV) &&
                     (cnt == ((len_q == RSP_LONG) ? CNT_W'(LONG_BITS - 1)
                                                  : CNT_W'(SHORT_BITS - 1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= ST_IDLE;
            len_q        <= RSP_NONE;
            cnt          <= '0;
            cmd_done     <= 1'b0;
            resp_done    <= 1'b0;
            resp_timeout <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (start_req) begin
                    st           <= ST_SEND;
                    cnt          <= '0;
                    len_q        <= decode_rsp(resp_kind);
                    cmd_done     <= 1'b0;
                    resp_done    <= 1'b0;
                    resp_timeout <= 1'b0;
                end
                ST_SEND: if (cnt == CNT_W'(CMD_BITS - 1)) begin
                    cmd_done <= 1'b1;
                    cnt      <= '0;
                    st       <= (len_q == RSP_NONE) ? ST_GAP : ST_WAIT;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                ST_WAIT: if (!cmd_in) begin
                    st  <= ST_RECV;
                    cnt <= CNT_W'(1);
                end else if (cnt == CNT_W'(TIMEOUT_CLKS - 1)) begin
                    resp_timeout <= 1'b1;
                    st           <= ST_HOLD;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                ST_RECV: if (rx_last) begin
                    resp_done <= 1'b1;
                    st        <= ST_HOLD;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                ST_GAP: if (cnt == CNT_W'(GAP_CLKS - 1)) st <= ST_HOLD;
                        else cnt <= cnt + 1'b1;
                ST_HOLD: if (!start_req) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    sdc_tx_shifter u_tx (
        .clk     (clk),
        .rst     (rst),
        .load    (go),
        .shift   (st == ST_SEND),
        .idx     (cmd_index),
        .arg     (cmd_arg),
        .bit_out (tx_bit)
    );

    sdc_rx_capture u_rx (
        .clk     (clk),
        .rst     (rst),
        .clear   (go),
        .shift   (rx_hit || (st == ST_RECV)),
        .finish  (rx_last),
        .is_long (len_q == RSP_LONG),
        .bit_in  (cmd_in),
        .w0      (resp_w0),
        .w1      (resp_w1),
        .w2      (resp_w2),
        .w3      (resp_w3),
        .crc_bad (resp_crc_err)
    );

    assign cmd_oe  = (st == ST_SEND);
    assign cmd_out = cmd_oe ? tx_bit : 1'b1;
    assign state_o = st;

endmodule

// File: rtl/sdc_cmd_checker.sv
module sdc_cmd_checker
    import sdc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        start_req,
    input logic [2:0]  state_o,
    input logic        cmd_oe,
    input logic        cmd_out,
    input logic        cmd_done,
    input logic        resp_done,
    input logic        resp_timeout,
    input logic [31:0] resp_w0
);

    AST_IDLE_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_IDLE && !start_req) |=> state_o == ST_IDLE); // R1

    AST_FIRST_BIT_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_oe) |-> !cmd_out); // R2

    AST_LINE_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !cmd_oe |-> cmd_out); // R2

    AST_DONE_FROM_SEND: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_done) |-> $past(state_o) == ST_SEND); // R4

    AST_WORDS_STABLE: assert property (@(posedge clk) disable iff (rst)
        (resp_done && $past(resp_done)) |-> $stable(resp_w0)); // R6

    AST_TIMEOUT_FROM_WAIT: assert property (@(posedge clk) disable iff (rst)
        $rose(resp_timeout) |-> $past(state_o) == ST_WAIT); // R9

    AST_DONE_XOR_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
        !(resp_done && resp_timeout)); // R9

    AST_HOLD_WHILE_REQ: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_HOLD && start_req) |=> state_o == ST_HOLD); // R11

endmodule

bind sd_cmd_sequencer sdc_cmd_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .start_req    (start_req),
    .state_o      (state_o),
    .cmd_oe       (cmd_oe),
    .cmd_out      (cmd_out),
    .cmd_done     (cmd_done),
    .resp_done    (resp_done),
    .resp_timeout (resp_timeout),
    .resp_w0      (resp_w0)
);

// File: tb/test_sd_cmd_sequencer.sv
`timescale 1ns/1ps
module test_sd_cmd_sequencer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_req = 1'b0;
    logic [5:0]  cmd_index = '0;
    logic [31:0] cmd_arg = '0;
    logic [1:0]  resp_kind = '0;
    logic        cmd_in = 1'b1;
    logic        cmd_out, cmd_oe, cmd_done, resp_done, resp_timeout, resp_crc_err;
    logic [2:0]  state_o;
    logic [31:0] resp_w0, resp_w1, resp_w2, resp_w3;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    sd_cmd_sequencer i_sd_cmd_sequencer (
        .clk(clk), .rst(rst), .start_req(start_req), .cmd_index(cmd_index),
        .cmd_arg(cmd_arg), .resp_kind(resp_kind), .cmd_in(cmd_in),
        .cmd_out(cmd_out), .cmd_oe(cmd_oe), .state_o(state_o),
        .cmd_done(cmd_done), .resp_done(resp_done), .resp_timeout(resp_timeout),
        .resp_crc_err(resp_crc_err), .resp_w0(resp_w0), .resp_w1(resp_w1),
        .resp_w2(resp_w2), .resp_w3(resp_w3)
    );

    function automatic logic [6:0] ref_crc7(input logic [39:0] d);
        logic [6:0] c;
        c = '0;
        for (int i = 39; i >= 0; i--) begin
            if (d[i] ^ c[6]) c = {c[5:0], 1'b0} ^ 7'h09;
            else             c = {c[5:0], 1'b0};
        end
        return c;
    endfunction

    task automatic chk(input string what, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", what, got, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // sends one command and checks the frame; leaves the bench at the
    // falling edge right after the last frame bit
    task automatic issue(input logic [5:0] idx, input logic [31:0] arg,
                         input logic [1:0] kind, input bit keep_req);
        logic [47:0] got;
        logic [47:0] exp;
        int          oe_lo;
        oe_lo     = 0;
        cmd_index = idx;
        cmd_arg   = arg;
        resp_kind = kind;
        start_req = 1'b1;
        @(negedge clk);
        chk("R2 send state", 64'(state_o), 64'd1);
        chk("R1 flags cleared at start",
            64'({cmd_done, resp_done, resp_timeout, resp_crc_err}), 64'd0);
        if (!keep_req) start_req = 1'b0;
        for (int i = 0; i < 48; i++) begin
            got[47 - i] = cmd_out;
            if (!cmd_oe) oe_lo++;
            @(negedge clk);
        end
        exp = {2'b01, idx, arg, ref_crc7({2'b01, idx, arg}), 1'b1};
        chk("R2 R3 frame bits", 64'(got), 64'(exp));
        chk("R2 oe over frame", 64'(oe_lo), 64'd0);
        chk("R2 oe after frame", 64'({cmd_oe, cmd_out}), 64'b01);
        chk("R4 cmd_done", 64'(cmd_done), 64'd1);
    endtask

    task automatic play(input logic [135:0] bits, input int n, input int delay);
        for (int d = 0; d < delay; d++) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            cmd_in = bits[n - 1 - i];
            @(negedge clk);
        end
        cmd_in = 1'b1;
    endtask

    task automatic t_reset();
        chk("R12 reset state", 64'(state_o), 64'd0);
        chk("R12 reset line", 64'({cmd_oe, cmd_out}), 64'b01);
        chk("R12 reset flags",
            64'({cmd_done, resp_done, resp_timeout, resp_crc_err}), 64'd0);
        chk("R12 reset words", 64'(resp_w0 | resp_w1 | resp_w2 | resp_w3), 64'd0);
    endtask

    task automatic t_idle();
        int moved;
        moved = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (state_o != 3'd0 || cmd_oe) moved++;
        end
        chk("R1 idle without request", 64'(moved), 64'd0);
    endtask

    task automatic t_crc_consts();
        chk("R3 crc index0", 64'(ref_crc7({2'b01, 6'd0, 32'd0})), 64'h4A);
        chk("R3 crc index17", 64'(ref_crc7({2'b01, 6'd17, 32'd0})), 64'h2A);
        issue(6'd0, 32'd0, 2'b00, 1'b0);
        repeat (10) @(negedge clk);
    endtask

    task automatic t_short(input logic [1:0] kind, input bit corrupt);
        logic [5:0]   idx;
        logic [31:0]  pay;
        logic [6:0]   c;
        logic [135:0] fr;
        idx = 6'd17;
        pay = corrupt ? 32'hC0FF_EE11 : 32'h0000_0900;
        c   = ref_crc7({2'b00, idx, pay});
        if (corrupt) c = ~c;
        fr  = 136'({2'b00, idx, pay, c, 1'b1});
        issue(idx, 32'h0000_0200, kind, 1'b0);
        chk("R9 wait state", 64'(state_o), 64'd2);
        play(fr, 48, 3);
        chk("R6 resp_done", 64'(resp_done), 64'd1);
        chk("R6 word0 payload", 64'(resp_w0), 64'(pay));
        chk("R6 word1 index", 64'(resp_w1), 64'(idx));
        chk("R6 upper words zero", 64'(resp_w2 | resp_w3), 64'd0);
        chk("R8 crc flag short", 64'(resp_crc_err), 64'(corrupt));
        chk("R5 R6 hold after reply", 64'(state_o), 64'd5);
        @(negedge clk);
        chk("R11 back to idle", 64'(state_o), 64'd0);
    endtask

    task automatic t_long();
        logic [127:0] p;
        p = {32'hA5A5_0001, 32'h1234_5678, 32'hDEAD_BEEF, 32'h0BAD_F00D};
        issue(6'd2, 32'd0, 2'b01, 1'b0);
        play({8'h3F, p}, 136, 0);
        chk("R5 R7 long done", 64'(resp_done), 64'd1);
        chk("R7 word3", 64'(resp_w3), 64'(p[127:96]));
        chk("R7 word2", 64'(resp_w2), 64'(p[95:64]));
        chk("R7 word1", 64'(resp_w1), 64'(p[63:32]));
        chk("R7 word0", 64'(resp_w0), 64'(p[31:0]));
        chk("R8 no crc flag long", 64'(resp_crc_err), 64'd0);
        @(negedge clk);
    endtask

    task automatic t_gap_hold();
        int stay;
        issue(6'd7, 32'h1111_2222, 2'b00, 1'b1);
        chk("R10 gap state", 64'(state_o), 64'd4);
        repeat (7) @(negedge clk);
        chk("R10 still gap", 64'(state_o), 64'd4);
        @(negedge clk);
        chk("R10 hold after gap", 64'(state_o), 64'd5);
        chk("R10 no reply flags", 64'({resp_done, resp_timeout}), 64'd0);
        stay = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (state_o != 3'd5) stay++;
        end
        chk("R11 hold while request high", 64'(stay), 64'd0);
        start_req = 1'b0;
        @(negedge clk);
        chk("R11 idle after release", 64'(state_o), 64'd0);
    endtask

    task automatic t_timeout();
        issue(6'd8, 32'h0000_01AA, 2'b10, 1'b0);
        repeat (63) @(negedge clk);
        chk("R9 no timeout before limit", 64'({resp_timeout, state_o}), 64'd2);
        @(negedge clk);
        chk("R9 timeout", 64'(resp_timeout), 64'd1);
        chk("R9 hold after timeout", 64'(state_o), 64'd5);
        @(negedge clk);
    endtask

    task automatic t_late_start();
        logic [135:0] fr;
        fr = 136'({2'b00, 6'd8, 32'h0000_01AA, ref_crc7({2'b00, 6'd8, 32'h0000_01AA}), 1'b1});
        issue(6'd8, 32'h0000_01AA, 2'b11, 1'b0);
        play(fr, 48, 63);
        chk("R9 last-edge start accepted", 64'({resp_done, resp_timeout}), 64'b10);
        chk("R9 late reply word0", 64'(resp_w0), 64'h0000_01AA);
        chk("R8 late reply crc ok", 64'(resp_crc_err), 64'd0);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got running expected finished");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_idle();
        t_crc_consts();
        t_short(2'b10, 1'b0);
        t_short(2'b11, 1'b1);
        t_long();
        t_gap_hold();
        t_timeout();
        t_late_start();
        repeat (4) @(negedge clk);
        summary();
    end

endmodule